// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

The block is a watchdog that counts a divided tick. When the count reaches a selectable period, it takes one of several actions: it raises an interrupt, it issues a one-cycle system-reset pulse, or it does the interrupt first and escalates to the reset if the interrupt is still pending at the next expiry. Software must restart the count with the `kick` input before the period runs out. An early-warning flag is set halfway through each period. A static `always_on` input forces reset behaviour whatever the enable bits hold. A latched reset-cause input `rst_flag` keeps the reset enable asserted.

Writes use a simple 8-bit port. The control register and the divider register are selected by `wr_sel`, and both registers are always visible on read buses. Two kinds of change are protected: lowering the reset enable, and changing the period code. Both are accepted only while an unlock window is open. A small state machine owns this window. Its state `UL_LOCKED` moves to `UL_OPEN` on the transition "arm", which is a control write with the change bit set. `UL_OPEN` returns to `UL_LOCKED` on the transition "expire", which happens after four cycles without a new arm. A new arm while in `UL_OPEN` restarts the window. The action mode is decoded from the enables into one of four named modes: `MD_STOP`, `MD_IRQ`, `MD_RST` and `MD_COMBO`.

Top module: `wdog_guard`

## Requirements
- R1: With `always_on` low and both enables 0 (mode `MD_STOP`), the counter does not run, and neither `wd_irq` nor `bark_rst` is ever raised.
- R2: With only the interrupt enable set (control bit 6), an expiry sets the time-out flag (control bit 7) and raises `wd_irq` (flag AND interrupt enable). No reset is issued.
- R3: With only the reset enable set (control bit 3), an expiry produces `bark_rst` high for exactly one cycle.
- R4: With both enables set, the first expiry raises `wd_irq`. If the flag is still set at the next expiry, `bark_rst` pulses instead.
- R5: `irq_ack` clears the time-out flag. In `MD_COMBO` it also clears the interrupt enable. If software then sets the interrupt enable again, the next expiry raises the interrupt rather than a reset.
- R6: With `always_on` high, the block behaves as `MD_RST` whatever the enables hold, and `wd_irq` stays low.
- R7: While the window is closed, a write that would clear the reset enable, or change the period code, leaves that field unchanged. Setting the reset enable and changing the interrupt enable are always accepted.
- R8: A control write with bit 4 set opens the window. Bit 4 reads 1 for the four cycles after that write and reads 0 afterwards.
- R9: While `rst_flag` is high, the reset enable reads 1 and cannot be cleared.
- R10: The period is 2^(BASE_LOG2+min(code,9)) ticks, and a tick occurs every 2^div clocks. `kick` restarts both the tick divider and the count. After a kick, the action appears 2^div · period clocks later.
- R11: After reset, both registers read 0x00. Bits 7:6 of the divider register always read 0.
- R12: At half the period, the early-warning flag (divider bit 4) is set, and `ew_irq` = flag AND early-warning enable (divider bit 3). The clear-mode bit is divider bit 5. When it is 0, `ew_ack` clears the flag. When it is 1, `ew_ack` has no effect, and only writing 1 to bit 4 clears the flag.
- R13: The 4-bit period code sits at control bit 5 (most significant) and bits 2:0. The tick divider select sits at divider bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| always_on | input | 1 | Static force to reset mode |
| rst_flag | input | 1 | Latched reset-cause flag; holds reset enable on |
| kick | input | 1 | Restart the count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = divider register |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Time-out interrupt serviced |
| ew_ack | input | 1 | Early-warning interrupt serviced |
| ctrl_rd | output | 8 | Control register readback |
| div_rd | output | 8 | Divider register readback |
| wd_irq | output | 1 | Time-out interrupt |
| ew_irq | output | 1 | Early-warning interrupt |
| bark_rst | output | 1 | One-cycle system-reset request |

## Verification
The assertions take `always_on` to be constant outside reset. They also take the unlock window to be observable only through control bit 4. The stimulus therefore changes `always_on` only while `rst_n` is low, and it issues every write through a single-cycle strobe task driven between clock edges. This keeps each write, acknowledge and kick to exactly one captured edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DIV_W = 3;
    localparam int PS_W  = 4;

    typedef enum logic [1:0] {
        MD_STOP,
        MD_IRQ,
        MD_RST,
        MD_COMBO
    } wd_mode_e;

    typedef enum logic {
        UL_LOCKED,
        UL_OPEN
    } unlock_st_e;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open
);
    localparam int CW = $clog2(WIN + 1);

    unlock_st_e st_q, st_d;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= UL_LOCKED;
            left_q <= '0;
        end else begin
            st_q <= st_d;
            if (arm)
                left_q <= CW'(WIN);
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UL_LOCKED: if (arm) st_d = UL_OPEN;
            UL_OPEN:   if (!arm && left_q == CW'(1)) st_d = UL_LOCKED;
            default:   st_d = UL_LOCKED;
        endcase
    end

    always_comb begin
        open = (st_q == UL_OPEN);
    end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = (PRE_W'(1) << sel) - PRE_W'(1);
        tick = (pre_q == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_period.sv
module wdog_period
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    input  logic [PS_W-1:0] code,
    output logic            expire,
    output logic            early
);
    localparam int CNT_W = BASE_LOG2 + MAX_CODE;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] half_m1;
    logic [PS_W-1:0]  eff;

    always_comb begin
        eff     = (code > PS_W'(MAX_CODE)) ? PS_W'(MAX_CODE) : code;
        last    = (CNT_W'(1) << (BASE_LOG2 + int'(eff))) - CNT_W'(1);
        half_m1 = (CNT_W'(1) << (BASE_LOG2 + int'(eff) - 1)) - CNT_W'(1);
        expire  = tick && (cnt_q == last);
        early   = tick && (cnt_q == half_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2  = 11,
    parameter int MAX_CODE   = 9,
    parameter int UNLOCK_WIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       always_on,
    input  logic       rst_flag,
    input  logic       kick,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       irq_ack,
    input  logic       ew_ack,
    output logic [7:0] ctrl_rd,
    output logic [7:0] div_rd,
    output logic       wd_irq,
    output logic       ew_irq,
    output logic       bark_rst
);
    logic            ie_q, re_q, to_flag_q, bark_q;
    logic            ew_flag_q, ew_ie_q, ew_swclr_q;
    logic [PS_W-1:0] pres_q;
    logic [DIV_W-1:0] div_q;

    wd_mode_e mode;
    logic win_open, tick, expire, early;
    logic ctrl_wr, div_wr, cnt_clr, to_irq, to_rst, combo_ack;

    assign ctrl_wr = wr_en && !wr_sel;
    assign div_wr  = wr_en && wr_sel;

    wdog_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (ctrl_wr && wr_data[4]),
        .open (win_open)
    );

    always_comb begin
        if (always_on) begin
            mode = MD_RST;
        end else begin
            unique case ({ie_q, re_q})
                2'b00:   mode = MD_STOP;
                2'b10:   mode = MD_IRQ;
                2'b01:   mode = MD_RST;
                default: mode = MD_COMBO;
            endcase
        end
        cnt_clr   = kick || (mode == MD_STOP);
        combo_ack = irq_ack && (mode == MD_COMBO);
    end

    wdog_tick u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .sel  (div_q),
        .tick (tick)
    );

    wdog_period #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .code  (pres_q),
        .expire(expire),
        .early (early)
    );

    always_comb begin
        to_irq = 1'b0;
        to_rst = 1'b0;
        if (expire) begin
            unique case (mode)
                MD_STOP:  ;
                MD_IRQ:   to_irq = 1'b1;
                MD_RST:   to_rst = 1'b1;
                MD_COMBO: if (to_flag_q) to_rst = 1'b1; else to_irq = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q       <= 1'b0;
            re_q       <= 1'b0;
            pres_q     <= '0;
            to_flag_q  <= 1'b0;
            bark_q     <= 1'b0;
            div_q      <= '0;
            ew_ie_q    <= 1'b0;
            ew_swclr_q <= 1'b0;
            ew_flag_q  <= 1'b0;
        end else begin
            if (combo_ack)
                ie_q <= 1'b0;
            else if (ctrl_wr)
                ie_q <= wr_data[6];

            if (rst_flag)
                re_q <= 1'b1;
            else if (ctrl_wr && (win_open || wr_data[3]))
                re_q <= wr_data[3];

            if (ctrl_wr && win_open)
                pres_q <= {wr_data[5], wr_data[2:0]};

            if (to_irq)
                to_flag_q <= 1'b1;
            else if (irq_ack || (ctrl_wr && wr_data[7]))
                to_flag_q <= 1'b0;

            bark_q <= to_rst;

            if (div_wr) begin
                ew_swclr_q <= wr_data[5];
                ew_ie_q    <= wr_data[3];
                div_q      <= wr_data[DIV_W-1:0];
            end

            if (early && (mode != MD_STOP))
                ew_flag_q <= 1'b1;
            else if ((ew_ack && !ew_swclr_q) || (div_wr && wr_data[4]))
                ew_flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd  = {to_flag_q, ie_q, pres_q[3], win_open, re_q, pres_q[2:0]};
        div_rd   = {2'b00, ew_swclr_q, ew_flag_q, ew_ie_q, div_q};
        wd_irq   = to_flag_q && ie_q;
        ew_irq   = ew_flag_q && ew_ie_q;
        bark_rst = bark_q;
    end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int WIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       always_on,
    input logic       rst_flag,
    input logic       ce_write,
    input logic [7:0] ctrl_rd,
    input logic       wd_irq,
    input logic       bark_rst
);
    logic [3:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (ce_write)
            left_q <= 4'(WIN);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bark_rst |=> !bark_rst); // R3
    AST_FUSE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        always_on |-> !wd_irq); // R6
    AST_PRES_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[4] |=> $stable({ctrl_rd[5], ctrl_rd[2:0]})); // R7
    AST_RE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[4] && ctrl_rd[3]) |=> ctrl_rd[3]); // R7
    AST_WIN_MODEL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[4] == (left_q != 4'd0)); // R8
    AST_RFLAG_HOLDS_RE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag |=> ctrl_rd[3]); // R9
endmodule

bind wdog_guard wdog_guard_chk #(.WIN(UNLOCK_WIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .always_on(always_on),
    .rst_flag (rst_flag),
    .ce_write (wr_en && !wr_sel && wr_data[4]),
    .ctrl_rd  (ctrl_rd),
    .wd_irq   (wd_irq),
    .bark_rst (bark_rst)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic always_on = 1'b0, rst_flag = 1'b0, kick = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0, irq_ack = 1'b0, ew_ack = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd, div_rd;
    logic wd_irq, ew_irq, bark_rst;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_guard #(.BASE_LOG2(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .always_on(always_on), .rst_flag(rst_flag),
        .kick(kick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_ack(irq_ack), .ew_ack(ew_ack), .ctrl_rd(ctrl_rd), .div_rd(div_rd),
        .wd_irq(wd_irq), .ew_irq(ew_irq), .bark_rst(bark_rst)
    );

    // div[25:23] code[22:19] ie[18] re[17] expect_reset[16] clocks[15:0]
    localparam logic [25:0] VEC [7] = '{
        {3'd0, 4'd0,  1'b0, 1'b1, 1'b1, 16'd16},
        {3'd0, 4'd2,  1'b1, 1'b0, 1'b0, 16'd64},
        {3'd2, 4'd1,  1'b0, 1'b1, 1'b1, 16'd128},
        {3'd1, 4'd3,  1'b1, 1'b0, 1'b0, 16'd256},
        {3'd0, 4'd12, 1'b0, 1'b1, 1'b1, 16'd8192},
        {3'd0, 4'd9,  1'b0, 1'b1, 1'b1, 16'd8192},
        {3'd3, 4'd0,  1'b0, 1'b1, 1'b1, 16'd128}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic cfg(input logic ie, input logic re, input logic [3:0] p,
                       input logic [2:0] d, input logic ewie);
        wr(1'b0, 8'h10);
        wr(1'b0, {1'b0, ie, p[3], 1'b0, re, p[2:0]});
        wr(1'b1, {4'b0000, ewie, d});
    endtask

    task automatic measure(output int n, output logic got_rst, output logic got_irq);
        kick = 1'b1;
        step();
        kick = 1'b0;
        n = 0; got_rst = 1'b0; got_irq = 1'b0;
        while (n < 20000 && !got_rst && !got_irq) begin
            step();
            n++;
            got_rst = bark_rst;
            got_irq = wd_irq;
        end
    endtask

    initial begin
        wait (cyc == 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic gr, gi, seen;

        do_reset();
        chk("R11 ctrl reset", ctrl_rd, 8'h00);
        chk("R11 div reset", div_rd, 8'h00);
        chk("R11 outputs reset", {wd_irq, ew_irq, bark_rst}, 3'b000);

        // Table: period, divider, clamp and action type (R2 R3 R10 R13)
        for (int i = 0; i < 7; i++) begin
            do_reset();
            cfg(VEC[i][18], VEC[i][17], VEC[i][22:19], VEC[i][25:23], 1'b0);
            measure(n, gr, gi);
            chk("R10 period clocks", n, {16'd0, VEC[i][15:0]});
            chk("R2 R3 action type", {gr, gi}, {VEC[i][16], !VEC[i][16]});
        end

        // R13 code split readback
        do_reset();
        cfg(1'b0, 1'b0, 4'd12, 3'd5, 1'b0);
        chk("R13 code bits", {ctrl_rd[5], ctrl_rd[2:0]}, 4'hC);
        chk("R13 div field", div_rd[2:0], 3'd5);
        wr(1'b1, 8'hFF);
        chk("R11 reserved bits zero", div_rd[7:6], 2'b00);

        // R1 stopped
        do_reset();
        cfg(1'b0, 1'b0, 4'd0, 3'd0, 1'b0);
        seen = 1'b0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (wd_irq || bark_rst) seen = 1'b1;
        end
        chk("R1 stopped no action", seen, 1'b0);

        // R8 window length
        do_reset();
        wr(1'b0, 8'h10);
        for (int k = 0; k < 4; k++) begin
            chk("R8 window open", ctrl_rd[4], 1'b1);
            step();
        end
        chk("R8 window closed", ctrl_rd[4], 1'b0);

        // R7 locked writes
        do_reset();
        wr(1'b0, 8'h0D);
        chk("R7 locked code ignored, re set", ctrl_rd, 8'h08);
        wr(1'b0, 8'h00);
        chk("R7 locked re clear ignored", ctrl_rd, 8'h08);
        wr(1'b0, 8'h10);
        wr(1'b0, 8'h05);
        chk("R7 unlocked write taken", ctrl_rd & 8'hEF, 8'h05);

        // R9 reset flag holds re
        do_reset();
        rst_flag = 1'b1;
        step();
        chk("R9 re forced", ctrl_rd[3], 1'b1);
        wr(1'b0, 8'h10);
        wr(1'b0, 8'h00);
        chk("R9 re not clearable", ctrl_rd[3], 1'b1);
        rst_flag = 1'b0;
        wr(1'b0, 8'h10);
        wr(1'b0, 8'h00);
        chk("R9 re clears after flag", ctrl_rd[3], 1'b0);

        // R6 always-on
        rst_n = 1'b0;
        always_on = 1'b1;
        step();
        do_reset();
        measure(n, gr, gi);
        chk("R6 forced reset period", n, 16);
        chk("R6 reset not irq", {gr, gi}, 2'b10);
        rst_n = 1'b0;
        always_on = 1'b0;
        step();

        // R10 kick restarts count
        do_reset();
        cfg(1'b0, 1'b1, 4'd0, 3'd0, 1'b0);
        kick = 1'b1; step(); kick = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step();
            if (bark_rst) seen = 1'b1;
        end
        measure(n, gr, gi);
        chk("R10 kick restart", {seen, n[15:0]}, {1'b0, 16'd16});

        // R4 escalation without service, R3 pulse width
        do_reset();
        cfg(1'b1, 1'b1, 4'd0, 3'd0, 1'b0);
        measure(n, gr, gi);
        chk("R4 first expiry irq", {n[7:0], gr, gi}, {8'd16, 2'b01});
        for (int k = 0; k < 16; k++) step();
        chk("R4 second expiry reset", bark_rst, 1'b1);
        step();
        chk("R3 single-cycle pulse", bark_rst, 1'b0);

        // R5 service then re-arm
        do_reset();
        cfg(1'b1, 1'b1, 4'd0, 3'd0, 1'b0);
        measure(n, gr, gi);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        chk("R5 ack clears flag and ie", {wd_irq, ctrl_rd[7], ctrl_rd[6]}, 3'b000);
        wr(1'b0, 8'h48);
        seen = 1'b0;
        for (int k = 18; k < 32; k++) begin
            step();
            if (bark_rst) seen = 1'b1;
        end
        chk("R5 re-armed expiry irq", {seen, wd_irq, bark_rst}, 3'b010);

        // R12 early warning
        do_reset();
        cfg(1'b1, 1'b0, 4'd0, 3'd0, 1'b1);
        kick = 1'b1; step(); kick = 1'b0;
        for (int k = 0; k < 7; k++) step();
        chk("R12 early not yet", ew_irq, 1'b0);
        step();
        chk("R12 early at half", ew_irq, 1'b1);
        ew_ack = 1'b1; step(); ew_ack = 1'b0;
        chk("R12 hw clear mode", ew_irq, 1'b0);
        wr(1'b1, 8'h28);
        for (int k = 10; k < 24; k++) step();
        chk("R12 early next period", ew_irq, 1'b1);
        ew_ack = 1'b1; step(); ew_ack = 1'b0;
        chk("R12 sw mode ignores ack", {ew_irq, div_rd[4]}, 2'b11);
        wr(1'b1, 8'h38);
        chk("R12 write one clears", {ew_irq, div_rd[4]}, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule